// File: doc/BRIEF.md
# SPI Target Port with Select-Driven Reset

This block is the target (slave) end of an SPI link. Every bit it sends or receives is moved by an edge of the serial clock that the external master drives. It never starts a transfer by itself, so a host that wants to read a byte must have the master send one. Each transfer runs through one shift register. It takes serial input from MOSI and drives MISO. A transmit buffer loaded by the host sits on one side of it, and a receive buffer read by the host sits on the other. All four clock modes are supported, set by a clock-polarity bit and a clock-phase bit. The bit order is selectable: most-significant bit first by default, least-significant bit first as the option.

The active-low select does more than enable the block. While it is high, the serial clock and data pins are ignored, the bit counter is held at zero and MISO is driven to 1, so several targets can share one wired-AND line. In the phase-0 modes, the falling edge of select is itself a load event: the transmit buffer moves into the shifter, so the first bit is already on MISO before the master's first clock edge.

The serial pins are oversampled on a local clock. Select always passes through a synchronizer. The clock and data synchronizers have a parameterised depth, and a depth of zero bypasses them to cut latency. Status flags report transmit-buffer empty, receive data waiting, byte complete and overrun. One interrupt output follows either the empty flag or the complete flag.

Top module: `spi_tgt`

## Requirements
- R1: After reset, spi_miso is 1, st_tx_empty is 1, st_rx_full, st_done and st_overrun are 0, and irq is 1 (with cfg_irq_on_done at 0).
- R2: While selected, bits move only on edges of spi_sclk. The leading edge is the first edge after idle, and the idle level equals cfg_cpol. With cfg_cpha=0, MOSI is sampled on the leading edge and MISO changes on the trailing edge. With cfg_cpha=1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. After DATA_W sample edges the received byte appears on rx_data.
- R3: With cfg_lsb_first=0, bit DATA_W-1 goes first in both directions. With cfg_lsb_first=1, bit 0 goes first.
- R4: While spi_ss_n is 1, spi_miso is 1 and spi_sclk and spi_mosi have no effect. A byte cut short by spi_ss_n rising is discarded: rx_data and st_rx_full are unchanged, and the next transfer starts again at its first bit.
- R5: With cfg_cpha=0, the falling edge of spi_ss_n loads the transmit buffer into the shifter, so the first bit is on spi_miso before any clock edge and st_tx_empty goes to 1. With cfg_cpha=1, nothing is loaded until the first leading edge. While select stays low, each following byte is loaded at the byte boundary.
- R6: A write via host_tx_wr clears st_tx_empty, and a load into the shifter sets it. If a load happens while the buffer is empty, the last written byte is sent again.
- R7: The end of each byte sets st_done and st_rx_full. A host_stat_rd pulse clears st_done and st_overrun. A host_rx_rd pulse clears st_rx_full.
- R8: If a byte completes while st_rx_full is still 1, st_overrun goes to 1 and rx_data takes the new byte.
- R9: irq equals st_done when cfg_irq_on_done is 1, and equals st_tx_empty when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 selects least-significant bit first |
| cfg_irq_on_done | input | 1 | Interrupt source: 1 = byte complete, 0 = transmit buffer empty |
| host_tx_wr | input | 1 | Write strobe for the transmit buffer |
| host_tx_data | input | DATA_W | Byte to transmit |
| host_rx_rd | input | 1 | Read strobe for the receive buffer |
| host_stat_rd | input | 1 | Status read strobe; clears complete and overrun |
| rx_data | output | DATA_W | Receive buffer contents |
| st_tx_empty | output | 1 | Transmit buffer has been taken by the shifter |
| st_rx_full | output | 1 | Unread byte in the receive buffer |
| st_done | output | 1 | A byte has completed since the last status read |
| st_overrun | output | 1 | A received byte overwrote an unread one |
| irq | output | 1 | Interrupt request |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low target select |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The hardest case to reach from the ports is a select that rises in the middle of a byte, followed by a clean byte. It must show that the partial bits never reach the receive buffer and that the bit counter really went back to zero. The master model sends half a byte, raises select, and then toggles the clock and data lines while the block is deselected. It checks that MISO stays high and that no receive flag appears. It then runs a full byte whose received and returned values are only correct if counting restarted at bit zero. A second hard case is the load at a byte boundary. The master model writes the next transmit byte in the middle of the current one, keeps select low across the boundary, and checks the second byte in phase 0 (trailing-edge load) and in phase 1 (leading-edge load).

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Widest data word the helper functions handle.
  localparam int unsigned MAXW = 32;

  // Bit presented on the serial output for a given shifter state.
  function automatic logic first_out(input logic [MAXW-1:0] v, input logic lsb,
                                     input int unsigned n);
    logic [MAXW-1:0] t;
    t = lsb ? v : (v >> (n - 1));
    return t[0];
  endfunction

  // Shift one received bit into an n-bit word; the outgoing bit leaves at the far end.
  function automatic logic [MAXW-1:0] shift_in(input logic [MAXW-1:0] v, input logic b,
                                               input logic lsb, input int unsigned n);
    logic [MAXW-1:0] m;
    logic [MAXW-1:0] r;
    m = (n >= MAXW) ? '1 : ((MAXW'(1) << n) - MAXW'(1));
    if (lsb) r = (v >> 1) | (MAXW'(b) << (n - 1));
    else     r = (v << 1) | MAXW'(b);
    return r & m;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ff <= {STAGES{RST_VAL}};
        end else begin
          ff[0] <= d;
          for (int i = 1; i < int'(STAGES); i++) ff[i] <= ff[i-1];
        end
      end
      assign q = ff[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              ss_n_s,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb,
  input  logic [DATA_W-1:0] tx_word,
  output logic              miso,
  output logic              tx_load,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_q, ss_q;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rxd;

  // Named events for the assertions and the neighbours.
  logic active, sel_start, rise, fall, lead_edge, trail_edge;
  logic sample_edge, shift_edge;

  assign active      = ~ss_n_s;
  assign sel_start   = ss_q & ~ss_n_s;
  assign rise        = sclk_s & ~sclk_q;
  assign fall        = ~sclk_s & sclk_q;
  assign lead_edge   = active & (cpol ? fall : rise);
  assign trail_edge  = active & (cpol ? rise : fall);
  assign sample_edge = cpha ? trail_edge : lead_edge;
  assign shift_edge  = cpha ? lead_edge : trail_edge;

  // A shift edge at count zero starts a byte: load instead of shift.
  // In phase 0 the select assertion is an extra load point.
  assign tx_load   = (shift_edge && cnt == '0) || (sel_start && !cpha);
  assign byte_done = sample_edge && cnt == LAST;
  assign rx_word   = DATA_W'(shift_in(MAXW'(sh), mosi_s, lsb, DATA_W));
  assign miso      = active ? first_out(MAXW'(sh), lsb, DATA_W) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
      sh     <= '0;
      cnt    <= '0;
      rxd    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_n_s;
      if (!active) begin
        cnt <= '0;
      end else begin
        if (sample_edge) begin
          rxd <= mosi_s;
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
        if (tx_load)         sh <= tx_word;
        else if (shift_edge) sh <= DATA_W'(shift_in(MAXW'(sh), rxd, lsb, DATA_W));
      end
    end
  end

  assert_cnt_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == '0);

  assert_shifter_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(sh));

  assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_edge, shift_edge}));

  assert_start_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && !cpha) |=> sh == $past(tx_word));

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_tx_wr,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_rd,
  input  logic              host_stat_rd,
  input  logic              tx_load,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              done,
  output logic              overrun
);

  logic lost_byte;
  assign lost_byte = byte_done && rx_full && !host_rx_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word  <= '0;
      tx_empty <= 1'b1;
      rx_data  <= '0;
      rx_full  <= 1'b0;
      done     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (host_tx_wr) begin
        tx_word  <= host_tx_data;
        tx_empty <= 1'b0;
      end else if (tx_load) begin
        tx_empty <= 1'b1;
      end

      if (byte_done) rx_data <= rx_word;

      if (byte_done)       rx_full <= 1'b1;
      else if (host_rx_rd) rx_full <= 1'b0;

      if (byte_done)         done <= 1'b1;
      else if (host_stat_rd) done <= 1'b0;

      if (lost_byte)         overrun <= 1'b1;
      else if (host_stat_rd) overrun <= 1'b0;
    end
  end

  assert_done_sets_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (done && rx_full));

  assert_overrun_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_byte |=> (overrun && rx_data == $past(rx_word)));

  assert_load_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !host_tx_wr) |=> tx_empty);

  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_wr |=> (!tx_empty && tx_word == $past(host_tx_data)));

endmodule

// File: rtl/spi_tgt.sv
module spi_tgt #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_irq_on_done,
  input  logic              host_tx_wr,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_rd,
  input  logic              host_stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              st_tx_empty,
  output logic              st_rx_full,
  output logic              st_done,
  output logic              st_overrun,
  output logic              irq,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              spi_miso
);

  // Select is always synchronised; at least one stage is kept.
  localparam int unsigned SEL_DEPTH = (SEL_STAGES == 0) ? 1 : SEL_STAGES;

  logic              sclk_s, mosi_s, ss_n_s;
  logic              tx_load, byte_done;
  logic [DATA_W-1:0] tx_word, rx_word;

  spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
  spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));
  spi_tgt_sync #(.STAGES(SEL_DEPTH), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(spi_ss_n), .q(ss_n_s));

  spi_tgt_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .ss_n_s    (ss_n_s),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .lsb       (cfg_lsb_first),
    .tx_word   (tx_word),
    .miso      (spi_miso),
    .tx_load   (tx_load),
    .byte_done (byte_done),
    .rx_word   (rx_word)
  );

  spi_tgt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_tx_wr   (host_tx_wr),
    .host_tx_data (host_tx_data),
    .host_rx_rd   (host_rx_rd),
    .host_stat_rd (host_stat_rd),
    .tx_load      (tx_load),
    .byte_done    (byte_done),
    .rx_word      (rx_word),
    .tx_word      (tx_word),
    .rx_data      (rx_data),
    .tx_empty     (st_tx_empty),
    .rx_full      (st_rx_full),
    .done         (st_done),
    .overrun      (st_overrun)
  );

  assign irq = cfg_irq_on_done ? st_done : st_tx_empty;

  assert_stat_read_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irq_on_done && host_stat_rd && !byte_done) |=> (!irq || !cfg_irq_on_done));

endmodule

// File: tb/test_spi_tgt.sv
module test_spi_tgt;

  localparam int W  = 8;
  localparam int HP = 8;   // local clocks per serial half period

  logic clk = 1'b0;
  always #4 clk = ~clk;    // 125 MHz

  logic         rst_n = 1'b0;
  logic         cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_irq_on_done = 1'b0;
  logic         host_tx_wr = 1'b0, host_rx_rd = 1'b0, host_stat_rd = 1'b0;
  logic [W-1:0] host_tx_data = '0;
  logic [W-1:0] rx_data;
  logic         st_tx_empty, st_rx_full, st_done, st_overrun, irq;
  logic         spi_sclk = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1;
  logic         spi_miso;

  spi_tgt #(.DATA_W(W)) i_spi_tgt (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_irq_on_done(cfg_irq_on_done),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_stat_rd(host_stat_rd),
    .rx_data(rx_data), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .st_done(st_done), .st_overrun(st_overrun), .irq(irq),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n), .spi_miso(spi_miso)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] exp_q[$];
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops the expected received byte whenever the receive buffer fills.
  always @(negedge clk) begin
    if (host_rx_rd) begin
      host_rx_rd = 1'b0;
    end else if (mon_en && st_rx_full) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected received byte", 32'(rx_data), 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R2 R3 received byte", 32'(rx_data), 32'(e));
      end
      host_rx_rd = 1'b1;
    end
  end

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic host_write(input logic [W-1:0] d);
    @(negedge clk);
    host_tx_wr = 1'b1;
    host_tx_data = d;
    @(negedge clk);
    host_tx_wr = 1'b0;
  endtask

  task automatic stat_read();
    @(negedge clk);
    host_stat_rd = 1'b1;
    @(negedge clk);
    host_stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic lsb);
    @(negedge clk);
    cfg_cpol = pol;
    cfg_cpha = pha;
    cfg_lsb_first = lsb;
    spi_sclk = pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic select_tgt();
    spi_ss_n = 1'b0;
    wait_hp();
  endtask

  task automatic deselect_tgt();
    wait_hp();
    spi_ss_n = 1'b1;
    wait_hp();
    wait_hp();
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Master model: moves nbits bits, optionally writing the next byte mid-way.
  task automatic spi_bits(input logic [W-1:0] mo, input int nbits, input bit wr_next,
                          input logic [W-1:0] nxt, output logic [W-1:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      int k;
      k = cfg_lsb_first ? i : W - 1 - i;
      if (!cfg_cpha) begin
        spi_mosi = mo[k];
        wait_hp();
        mi[k] = spi_miso;
        spi_sclk = ~cfg_cpol;
        wait_hp();
        spi_sclk = cfg_cpol;
      end else begin
        spi_sclk = ~cfg_cpol;
        spi_mosi = mo[k];
        wait_hp();
        mi[k] = spi_miso;
        spi_sclk = cfg_cpol;
        wait_hp();
      end
      if (wr_next && i == 3) host_write(nxt);
    end
  endtask

  // Driver: one full byte; pushes the expected received byte for the monitor.
  task automatic xfer(input logic [W-1:0] mo, input logic [W-1:0] exp_mi,
                      input bit wr_next, input logic [W-1:0] nxt, input string req);
    logic [W-1:0] mi;
    exp_q.push_back(mo);
    spi_bits(mo, W, wr_next, nxt, mi);
    check(mi == exp_mi, req, 32'(mi), 32'(exp_mi));
  endtask

  task automatic single(input logic [W-1:0] txb, input logic [W-1:0] mo, input string req);
    host_write(txb);
    select_tgt();
    xfer(mo, txb, 1'b0, '0, req);
    deselect_tgt();
    check(spi_miso == 1'b1, "R4 miso idle after select rises", 32'(spi_miso), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [W-1:0] mi;
    logic [W-1:0] held;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(spi_miso == 1'b1, "R1 miso after reset", 32'(spi_miso), 1);
    check(st_tx_empty == 1'b1, "R1 tx empty after reset", 32'(st_tx_empty), 1);
    check({st_rx_full, st_done, st_overrun} == 3'b000, "R1 status after reset",
          32'({st_rx_full, st_done, st_overrun}), 0);
    check(irq == 1'b1, "R1 irq after reset", 32'(irq), 1);

    mon_en = 1'b1;

    // Mode 0, MSB first; R5 load at select, R9 irq follows tx empty
    set_mode(1'b0, 1'b0, 1'b0);
    host_write(8'hA5);
    check(irq == 1'b0, "R9 irq low once tx written", 32'(irq), 0);
    select_tgt();
    check(st_tx_empty == 1'b1, "R5 phase-0 select loads tx", 32'(st_tx_empty), 1);
    check(irq == 1'b1, "R9 irq high after tx taken", 32'(irq), 1);
    xfer(8'h3C, 8'hA5, 1'b0, '0, "R2 mode0 msb miso byte");
    deselect_tgt();

    // Mode 1: no load before the first leading edge (R5)
    set_mode(1'b0, 1'b1, 1'b0);
    host_write(8'h96);
    select_tgt();
    check(st_tx_empty == 1'b0, "R5 phase-1 select does not load", 32'(st_tx_empty), 0);
    xfer(8'h4D, 8'h96, 1'b0, '0, "R2 mode1 msb miso byte");
    deselect_tgt();

    // Modes 2 and 3, LSB first (R3)
    set_mode(1'b1, 1'b0, 1'b1);
    single(8'h1E, 8'hC4, "R3 mode2 lsb miso byte");
    set_mode(1'b1, 1'b1, 1'b1);
    single(8'h2B, 8'h0D, "R3 mode3 lsb miso byte");

    // Two bytes inside one select, phase 0 then phase 1 (R5)
    set_mode(1'b0, 1'b0, 1'b1);
    host_write(8'h71);
    select_tgt();
    xfer(8'hC8, 8'h71, 1'b1, 8'h6B, "R5 mode0 first of two");
    xfer(8'h29, 8'h6B, 1'b0, '0, "R5 mode0 boundary load");
    deselect_tgt();
    set_mode(1'b1, 1'b1, 1'b0);
    host_write(8'h47);
    select_tgt();
    xfer(8'h83, 8'h47, 1'b1, 8'hD2, "R5 mode3 first of two");
    xfer(8'h5E, 8'hD2, 1'b0, '0, "R5 mode3 boundary load");
    deselect_tgt();

    // Empty buffer repeats the last byte (R6)
    set_mode(1'b0, 1'b0, 1'b0);
    single(8'h5A, 8'h17, "R6 byte before repeat");
    check(st_tx_empty == 1'b1, "R6 tx empty after use", 32'(st_tx_empty), 1);
    select_tgt();
    xfer(8'hE4, 8'h5A, 1'b0, '0, "R6 empty buffer repeats last byte");
    deselect_tgt();
    drain();

    // Partial byte, then clock activity while deselected (R4)
    held = rx_data;
    host_write(8'h99);
    select_tgt();
    spi_bits(8'hF0, 4, 1'b0, '0, mi);
    deselect_tgt();
    check(st_rx_full == 1'b0, "R4 partial byte not received", 32'(st_rx_full), 0);
    check(rx_data == held, "R4 rx data kept after partial byte", 32'(rx_data), 32'(held));
    for (int i = 0; i < 5; i++) begin
      spi_mosi = i[0];
      spi_sclk = ~spi_sclk;
      wait_hp();
      spi_sclk = ~spi_sclk;
      wait_hp();
      check(spi_miso == 1'b1, "R4 miso high while deselected", 32'(spi_miso), 1);
    end
    check(st_rx_full == 1'b0, "R4 clocks ignored while deselected", 32'(st_rx_full), 0);
    single(8'h35, 8'hE1, "R4 clean byte after aborted one");
    drain();
    check(st_rx_full == 1'b0, "R7 rx read clears full", 32'(st_rx_full), 0);

    // Overrun (R8) and status clearing (R7)
    mon_en = 1'b0;
    stat_read();
    check(st_done == 1'b0, "R7 status read clears done", 32'(st_done), 0);
    single(8'h11, 8'h6C, "R8 first unread byte");
    void'(exp_q.pop_back());
    check(st_overrun == 1'b0, "R8 no overrun on first byte", 32'(st_overrun), 0);
    single(8'h22, 8'hB3, "R8 second unread byte");
    check(st_overrun == 1'b1, "R8 overrun flagged", 32'(st_overrun), 1);
    check(rx_data == 8'hB3, "R8 rx buffer overwritten", 32'(rx_data), 32'hB3);
    check(st_done == 1'b1, "R7 done set", 32'(st_done), 1);
    stat_read();
    check({st_overrun, st_done} == 2'b00, "R7 status read clears done and overrun",
          32'({st_overrun, st_done}), 0);
    check(st_rx_full == 1'b1, "R7 status read keeps rx full", 32'(st_rx_full), 1);
    mon_en = 1'b1;
    drain();

    // Interrupt on completion (R9)
    @(negedge clk);
    cfg_irq_on_done = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R9 irq follows done (clear)", 32'(irq), 0);
    single(8'hC3, 8'h58, "R9 byte for completion irq");
    check(irq == 1'b1, "R9 irq raised on completion", 32'(irq), 1);
    stat_read();
    check(irq == 1'b0, "R9 irq dropped by status read", 32'(irq), 0);
    drain();
    check(exp_q.size() == 0, "R2 all expected bytes received", 32'(exp_q.size()), 0);

    report();
  end

endmodule